// File: doc/BRIEF.md
# Masked Privileged Control Register File

This block holds the privileged control registers of one processor core. Each register is 64 bits wide and sits behind a single index-addressed access port. Every register applies its own rule when written. Most keep only a fixed set of field bits. Some clear themselves on any write, and one accepts a single write in its lifetime. Others are not readable, and the invalidate entries exist mainly to produce one-cycle strobes toward the translation buffers. Reads return stored contents, with one exception: the cycle-count register merges its stored upper half with a free-running counter.

One access is presented per cycle on `acc_en_i`, with `acc_wr_i` choosing between write and read. All results appear on the clock edge that accepts the access and last for exactly one cycle: the read data, the error flag and the invalidate strobes. While the speculation qualifier `spec_i` is high, every write and every strobe is dropped, and no error is raised for the dropped writes. The set-once control register is sequenced by a two-state machine. It starts in ONCE_OPEN. The first accepted write moves it to ONCE_SPENT and it never returns while out of reset. In ONCE_SPENT the register reads 1 and every further accepted write raises the error flag.

Index map (decimal): 0-7 scratch, 8 handler base, 9 miscellaneous control, 10 exception address, 11 trap request, 12 trap enable, 13 priority level, 14 software request, 15 instruction mode, 16 data mode, 17 instruction-stream control, 18 instruction page-table base, 19 data page-table base, 20 instruction ASN, 21 data ASN, 22 cache test, 23 cache mode, 24 miss-file mode, 25 exception summary, 26 exception mask, 27 cycle count, 28 cycle-count control, 29-32 read-only, 33/34/35 instruction-side invalidate all/process/single, 36/37/38 data-side invalidate all/process/single, 39 flush, 40 interrupt clear, 41-63 unknown.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every readable index reads zero, with three exceptions: index 9 reads 0x6, index 8 reads parameter HBASE_RST, and scratch index ID_SLOT (default 6) reads `cpu_id` zero-extended.
- R2: A read accepted at a clock edge drives `rd_valid_o` high with its data in the following cycle only; `rd_data_o` is zero whenever `rd_valid_o` is low.
- R3: Writes keep only these bits: indices 11 and 12 mask 0xF; 13 mask 0x1F; 14 mask 0x7FFF0; 15 and 16 mask 0x18; 17 mask 0xFF_FFFF_0300; 18 and 19 mask 0xFFFF_FFFF_C000_0000; 20 mask 0x7F0; 21 mask 0xFE00_0000_0000_0000; 22 mask 0x1FFB; 23 and 24 mask 0x3F; indices 0-9 and 27 keep all 64 bits.
- R4: A write to index 10 stores the data with bit 1 forced to zero.
- R5: Any write to index 25 or 26 leaves it zero, whatever the data.
- R6: A read of index 27 returns the stored bits [63:32] with bits [31:0] taken from a counter that advances by one every clock after reset.
- R7: Index 28 reads 0 until its first accepted write, then reads 1; every later accepted write raises `err_o` and leaves it at 1.
- R8: A write to indices 29-32 raises `err_o` and changes nothing; these indices read zero.
- R9: A read of indices 33-40 raises `err_o` and returns zero data.
- R10: Any read or write of indices 41-63 raises `err_o`, which is high for the cycle after the access only.
- R11: A write to index 33/34 (36/37) pulses bit 0 (bit 1) of `inv_all_o`/`inv_proc_o` for one cycle, one cycle after the write.
- R12: A write to index 35 (38) pulses bit 0 (bit 1) of `inv_one_o` with `inv_addr_o` equal to the written data and `inv_asn_o` equal to bits [10:4] of index 20 (bits [63:57] of index 21); both buses are zero when no single strobe is high.
- R13: While `spec_i` is high a write changes no register, raises no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_id | input | ID_W | Core identifier loaded into one scratch register at reset |
| spec_i | input | 1 | Speculation qualifier, drops writes while high |
| acc_en_i | input | 1 | Access valid |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 6 | Register index |
| acc_wdata_i | input | 64 | Write data |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Read result |
| err_o | output | 1 | Illegal access flag |
| inv_all_o | output | 2 | Invalidate-all strobes (bit 0 instruction side, bit 1 data side) |
| inv_proc_o | output | 2 | Invalidate-process strobes |
| inv_one_o | output | 2 | Invalidate-single strobes |
| inv_addr_o | output | 64 | Address for a single invalidate |
| inv_asn_o | output | 7 | Address-space number for a single invalidate |

## Verification
Every result of this block is due exactly one clock after the edge that accepts the access: read data and valid, the error flag, and all strobes with their address and ASN. The bench drives each access on the falling edge, lets one rising edge take it, and samples 1 ns later, so each check reads the result of the access just made and nothing older. The cycle-count field is not compared with an absolute value. Two reads a known number of edges apart must differ by that number. Sweeping all 64 indices with four data patterns, after reset and after writes, covers every write rule and every error case.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int DW       = 64;
    localparam int IDX_W    = 6;
    localparam int NSCR     = 8;
    localparam int ASN_W    = 7;
    localparam int CYC_LO_W = 32;
    localparam int ASN_I_LSB = 4;
    localparam int ASN_D_LSB = 57;

    localparam logic [IDX_W-1:0] IX_HBASE    = IDX_W'(8);
    localparam logic [IDX_W-1:0] IX_MISC     = IDX_W'(9);
    localparam logic [IDX_W-1:0] IX_EXC_ADDR = IDX_W'(10);
    localparam logic [IDX_W-1:0] IX_TRAP_REQ = IDX_W'(11);
    localparam logic [IDX_W-1:0] IX_TRAP_ENA = IDX_W'(12);
    localparam logic [IDX_W-1:0] IX_PRI_LVL  = IDX_W'(13);
    localparam logic [IDX_W-1:0] IX_SW_REQ   = IDX_W'(14);
    localparam logic [IDX_W-1:0] IX_MODE_I   = IDX_W'(15);
    localparam logic [IDX_W-1:0] IX_MODE_D   = IDX_W'(16);
    localparam logic [IDX_W-1:0] IX_ISTR_CTL = IDX_W'(17);
    localparam logic [IDX_W-1:0] IX_PTB_I    = IDX_W'(18);
    localparam logic [IDX_W-1:0] IX_PTB_D    = IDX_W'(19);
    localparam logic [IDX_W-1:0] IX_ASN_I    = IDX_W'(20);
    localparam logic [IDX_W-1:0] IX_ASN_D    = IDX_W'(21);
    localparam logic [IDX_W-1:0] IX_CTEST    = IDX_W'(22);
    localparam logic [IDX_W-1:0] IX_CMODE    = IDX_W'(23);
    localparam logic [IDX_W-1:0] IX_MFMODE   = IDX_W'(24);
    localparam logic [IDX_W-1:0] IX_EXC_SUM  = IDX_W'(25);
    localparam logic [IDX_W-1:0] IX_EXC_MSK  = IDX_W'(26);
    localparam logic [IDX_W-1:0] IX_CYC      = IDX_W'(27);
    localparam logic [IDX_W-1:0] IX_CYC_CTL  = IDX_W'(28);
    localparam logic [IDX_W-1:0] IX_RO_0     = IDX_W'(29);
    localparam logic [IDX_W-1:0] IX_RO_1     = IDX_W'(30);
    localparam logic [IDX_W-1:0] IX_RO_2     = IDX_W'(31);
    localparam logic [IDX_W-1:0] IX_RO_3     = IDX_W'(32);
    localparam logic [IDX_W-1:0] IX_IALL_I   = IDX_W'(33);
    localparam logic [IDX_W-1:0] IX_IPROC_I  = IDX_W'(34);
    localparam logic [IDX_W-1:0] IX_IONE_I   = IDX_W'(35);
    localparam logic [IDX_W-1:0] IX_IALL_D   = IDX_W'(36);
    localparam logic [IDX_W-1:0] IX_IPROC_D  = IDX_W'(37);
    localparam logic [IDX_W-1:0] IX_IONE_D   = IDX_W'(38);
    localparam logic [IDX_W-1:0] IX_FLUSH    = IDX_W'(39);
    localparam logic [IDX_W-1:0] IX_INT_CLR  = IDX_W'(40);
    localparam int NREG = int'(IX_INT_CLR) + 1;

    typedef enum logic [3:0] {
        RK_NONE, RK_KEEP, RK_CLEAR, RK_ONCE, RK_CYC, RK_RO,
        RK_WO, RK_INV_ALL, RK_INV_PROC, RK_INV_ONE
    } rule_e;

    typedef struct packed {
        rule_e           kind;
        logic            side;   // 0 instruction side, 1 data side
        logic [DW-1:0]   mask;
    } rule_t;

    function automatic rule_t rule_of(input logic [IDX_W-1:0] ix);
        rule_t r;
        r.kind = RK_NONE;
        r.side = 1'b0;
        r.mask = '1;
        if (int'(ix) < NSCR) begin
            r.kind = RK_KEEP;
        end else begin
            case (ix)
                IX_HBASE, IX_MISC, IX_EXC_ADDR, IX_TRAP_REQ, IX_TRAP_ENA,
                IX_PRI_LVL, IX_SW_REQ, IX_MODE_I, IX_MODE_D, IX_ISTR_CTL,
                IX_PTB_I, IX_PTB_D, IX_ASN_I, IX_ASN_D, IX_CTEST,
                IX_CMODE, IX_MFMODE:           r.kind = RK_KEEP;
                IX_EXC_SUM, IX_EXC_MSK:        r.kind = RK_CLEAR;
                IX_CYC:                        r.kind = RK_CYC;
                IX_CYC_CTL:                    r.kind = RK_ONCE;
                IX_RO_0, IX_RO_1, IX_RO_2, IX_RO_3: r.kind = RK_RO;
                IX_FLUSH, IX_INT_CLR:          r.kind = RK_WO;
                IX_IALL_I, IX_IALL_D:          r.kind = RK_INV_ALL;
                IX_IPROC_I, IX_IPROC_D:        r.kind = RK_INV_PROC;
                IX_IONE_I, IX_IONE_D:          r.kind = RK_INV_ONE;
                default:                       r.kind = RK_NONE;
            endcase
            case (ix)
                IX_EXC_ADDR:              r.mask = ~64'h2;
                IX_TRAP_REQ, IX_TRAP_ENA: r.mask = 64'hF;
                IX_PRI_LVL:               r.mask = 64'h1F;
                IX_SW_REQ:                r.mask = 64'h7_FFF0;
                IX_MODE_I, IX_MODE_D:     r.mask = 64'h18;
                IX_ISTR_CTL:              r.mask = 64'hFF_FFFF_0300;
                IX_PTB_I, IX_PTB_D:       r.mask = 64'hFFFF_FFFF_C000_0000;
                IX_ASN_I:                 r.mask = 64'h7F0;
                IX_ASN_D:                 r.mask = 64'hFE00_0000_0000_0000;
                IX_CTEST:                 r.mask = 64'h1FFB;
                IX_CMODE, IX_MFMODE:      r.mask = 64'h3F;
                default:                  r.mask = '1;
            endcase
            r.side = (ix == IX_IALL_D) || (ix == IX_IPROC_D) || (ix == IX_IONE_D);
        end
        return r;
    endfunction
endpackage

// File: rtl/crb_cycle_ctr.sv
module crb_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + W'(1);
    end
endmodule

// File: rtl/crb_once_fsm.sv
module crb_once_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic set_o,
    output logic err_o
);
    typedef enum logic {ONCE_OPEN, ONCE_SPENT} once_e;
    once_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ONCE_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d  = st_q;
        set_o = 1'b0;
        err_o = 1'b0;
        unique case (st_q)
            ONCE_OPEN: begin
                if (hit_i) st_d = ONCE_SPENT;
            end
            ONCE_SPENT: begin
                set_o = 1'b1;
                err_o = hit_i;
            end
        endcase
    end
endmodule

// File: rtl/crb_inval_gen.sv
module crb_inval_gen #(
    parameter int DW    = 64,
    parameter int ASN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_all_i,
    input  logic             fire_proc_i,
    input  logic             fire_one_i,
    input  logic [DW-1:0]    addr_i,
    input  logic [ASN_W-1:0] asn_i,
    output logic             all_o,
    output logic             proc_o,
    output logic             one_o,
    output logic [DW-1:0]    addr_o,
    output logic [ASN_W-1:0] asn_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_o  <= 1'b0;
            proc_o <= 1'b0;
            one_o  <= 1'b0;
            addr_o <= '0;
            asn_o  <= '0;
        end else begin
            all_o  <= fire_all_i;
            proc_o <= fire_proc_i;
            one_o  <= fire_one_i;
            addr_o <= fire_one_i ? addr_i : '0;
            asn_o  <= fire_one_i ? asn_i  : '0;
        end
    end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import crb_pkg::*;
#(
    parameter logic [63:0] HBASE_RST = 64'h0000_0000_0000_8000,
    parameter int          ID_W      = 8,
    parameter int          ID_SLOT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic              spec_i,
    input  logic              acc_en_i,
    input  logic              acc_wr_i,
    input  logic [5:0]        acc_idx_i,
    input  logic [63:0]       acc_wdata_i,
    output logic              rd_valid_o,
    output logic [63:0]       rd_data_o,
    output logic              err_o,
    output logic [1:0]        inv_all_o,
    output logic [1:0]        inv_proc_o,
    output logic [1:0]        inv_one_o,
    output logic [63:0]       inv_addr_o,
    output logic [6:0]        inv_asn_o
);
    localparam int NSIDE = 2;

    rule_t acc_rule;
    logic  wr_req, rd_req, store_en, once_hit, once_set, once_err, err_d;
    logic  wr_bad, rd_bad;
    logic [DW-1:0] store_val, rd_val;
    logic [DW-1:0] regs [NREG];
    logic [CYC_LO_W-1:0] cyc_lo;

    function automatic logic [DW-1:0] rst_val(input int i, input logic [ID_W-1:0] id);
        if (i == int'(IX_MISC))  return DW'(6);
        if (i == int'(IX_HBASE)) return HBASE_RST;
        if (i == ID_SLOT)        return DW'(id);
        return '0;
    endfunction

    assign acc_rule = rule_of(acc_idx_i);
    assign wr_req   = acc_en_i && acc_wr_i && !spec_i;
    assign rd_req   = acc_en_i && !acc_wr_i;
    assign once_hit = wr_req && (acc_rule.kind == RK_ONCE);

    assign store_en = wr_req && (acc_rule.kind inside
        {RK_KEEP, RK_CLEAR, RK_CYC, RK_WO, RK_INV_ALL, RK_INV_PROC, RK_INV_ONE});
    assign wr_bad   = wr_req && (acc_rule.kind inside {RK_RO, RK_NONE});
    assign rd_bad   = rd_req && (acc_rule.kind inside
        {RK_WO, RK_INV_ALL, RK_INV_PROC, RK_INV_ONE, RK_NONE});
    assign err_d    = wr_bad || rd_bad || once_err;

    always_comb begin
        unique case (acc_rule.kind)
            RK_CLEAR, RK_INV_ALL, RK_INV_PROC: store_val = '0;
            default:                           store_val = acc_wdata_i & acc_rule.mask;
        endcase
    end

    always_comb begin
        rd_val = '0;
        unique case (acc_rule.kind)
            RK_KEEP, RK_CLEAR, RK_RO: rd_val = regs[acc_idx_i];
            RK_CYC:  rd_val = {regs[acc_idx_i][DW-1:CYC_LO_W], cyc_lo};
            RK_ONCE: rd_val = {{(DW-1){1'b0}}, once_set};
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i, cpu_id);
        end else if (store_en) begin
            regs[acc_idx_i] <= store_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            err_o      <= 1'b0;
        end else begin
            rd_valid_o <= rd_req;
            rd_data_o  <= rd_req ? rd_val : '0;
            err_o      <= err_d;
        end
    end

    crb_cycle_ctr #(.W(CYC_LO_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (cyc_lo)
    );

    crb_once_fsm u_once (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (once_hit),
        .set_o (once_set),
        .err_o (once_err)
    );

    logic [ASN_W-1:0] cur_asn  [NSIDE];
    logic [ASN_W-1:0] side_asn [NSIDE];
    logic [DW-1:0]    side_addr[NSIDE];

    assign cur_asn[0] = regs[IX_ASN_I][ASN_I_LSB +: ASN_W];
    assign cur_asn[1] = regs[IX_ASN_D][ASN_D_LSB +: ASN_W];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic on_side;
        assign on_side = (acc_rule.side == 1'(s));
        crb_inval_gen #(.DW(DW), .ASN_W(ASN_W)) u_gen (
            .clk         (clk),
            .rst_n       (rst_n),
            .fire_all_i  (wr_req && on_side && (acc_rule.kind == RK_INV_ALL)),
            .fire_proc_i (wr_req && on_side && (acc_rule.kind == RK_INV_PROC)),
            .fire_one_i  (wr_req && on_side && (acc_rule.kind == RK_INV_ONE)),
            .addr_i      (acc_wdata_i),
            .asn_i       (cur_asn[s]),
            .all_o       (inv_all_o[s]),
            .proc_o      (inv_proc_o[s]),
            .one_o       (inv_one_o[s]),
            .addr_o      (side_addr[s]),
            .asn_o       (side_asn[s])
        );
    end

    assign inv_addr_o = side_addr[0] | side_addr[1];
    assign inv_asn_o  = side_asn[0]  | side_asn[1];
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        spec_i,
    input logic        acc_en_i,
    input logic        acc_wr_i,
    input logic        rd_valid_o,
    input logic [63:0] rd_data_o,
    input logic        err_o,
    input logic [1:0]  inv_all_o,
    input logic [1:0]  inv_proc_o,
    input logic [1:0]  inv_one_o,
    input logic [63:0] inv_addr_o,
    input logic [6:0]  inv_asn_o
);
    p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_wr_i) |=> rd_valid_o);

    p_rd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(acc_en_i && !acc_wr_i));

    p_idle_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (rd_data_o == 64'h0));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(acc_en_i));

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_all_o, inv_proc_o, inv_one_o}));

    p_strobe_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|{inv_all_o, inv_proc_o, inv_one_o}) |-> $past(acc_en_i && acc_wr_i && !spec_i));

    p_addr_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one_o == 2'b00) |-> (inv_addr_o == 64'h0 && inv_asn_o == 7'h0));

    p_spec_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_wr_i && spec_i) |=>
            (!err_o && inv_all_o == 2'b00 && inv_proc_o == 2'b00 && inv_one_o == 2'b00));
endmodule

bind ctlreg_bank ctlreg_bank_chk u_chk (.*);

// File: tb/ctlreg_bank_bench.sv
`timescale 1ns/1ps
module ctlreg_bank_bench;
    localparam logic [63:0] HB      = 64'h0000_0000_0000_8000;
    localparam logic [7:0]  CPU     = 8'h5C;
    localparam int          ID_SLOT = 6;

    localparam int K_NONE = 0, K_PLAIN = 1, K_CLR = 2, K_ONCE = 3, K_CYC = 4,
                   K_RO = 5, K_WO = 6, K_IALL = 7, K_IPROC = 8, K_IONE = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_id = CPU;
    logic        spec_i = 1'b0, acc_en_i = 1'b0, acc_wr_i = 1'b0;
    logic [5:0]  acc_idx_i = '0;
    logic [63:0] acc_wdata_i = '0;
    logic        rd_valid_o, err_o;
    logic [63:0] rd_data_o, inv_addr_o;
    logic [1:0]  inv_all_o, inv_proc_o, inv_one_o;
    logic [6:0]  inv_asn_o;

    int checks = 0, bad = 0;
    bit done = 0;
    logic [63:0] m [64];
    bit once_flag = 0;

    always #4 clk = ~clk;

    ctlreg_bank #(.HBASE_RST(HB), .ID_W(8), .ID_SLOT(ID_SLOT)) u_ctlreg_bank (.*);

    function automatic int kind_of(int ix);
        if (ix <= 24) return K_PLAIN;
        if (ix == 25 || ix == 26) return K_CLR;
        if (ix == 27) return K_CYC;
        if (ix == 28) return K_ONCE;
        if (ix <= 32) return K_RO;
        if (ix == 33 || ix == 36) return K_IALL;
        if (ix == 34 || ix == 37) return K_IPROC;
        if (ix == 35 || ix == 38) return K_IONE;
        if (ix <= 40) return K_WO;
        return K_NONE;
    endfunction

    function automatic logic [63:0] mask_of(int ix);
        case (ix)
            10:     return ~64'h2;
            11, 12: return 64'hF;
            13:     return 64'h1F;
            14:     return 64'h7FFF0;
            15, 16: return 64'h18;
            17:     return 64'hFF_FFFF_0300;
            18, 19: return 64'hFFFF_FFFF_C000_0000;
            20:     return 64'h7F0;
            21:     return 64'hFE00_0000_0000_0000;
            22:     return 64'h1FFB;
            23, 24: return 64'h3F;
            default: return '1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input bit sp, input int ix, input logic [63:0] d);
        @(negedge clk);
        acc_en_i = 1'b1; acc_wr_i = wr; spec_i = sp;
        acc_idx_i = 6'(ix); acc_wdata_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en_i = 1'b0; acc_wr_i = 1'b0; spec_i = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic check_read(input int ix, input string tag);
        int k;
        logic [63:0] exp;
        bit exp_err;
        k = kind_of(ix);
        do_op(1'b0, 1'b0, ix, 64'h0);
        exp_err = (k == K_WO || k == K_IALL || k == K_IPROC || k == K_IONE || k == K_NONE);
        chk(rd_valid_o == 1'b1, "R2 read valid", 64'(rd_valid_o), 64'h1);
        chk(err_o == exp_err, exp_err ? (k == K_NONE ? "R10 read err" : "R9 read err") : "R2 read no err",
            64'(err_o), 64'(exp_err));
        if (k == K_CYC) begin
            chk(rd_data_o[63:32] == m[ix][63:32], "R6 cycle upper", rd_data_o, m[ix]);
        end else begin
            case (k)
                K_PLAIN, K_CLR, K_RO: exp = m[ix];
                K_ONCE:               exp = 64'(once_flag);
                default:              exp = 64'h0;
            endcase
            chk(rd_data_o == exp, tag, rd_data_o, exp);
        end
    endtask

    task automatic check_write(input int ix, input logic [63:0] p);
        int k, side;
        bit exp_err;
        logic [1:0] e_all, e_proc, e_one;
        logic [6:0] e_asn;
        k = kind_of(ix);
        side = (ix >= 36) ? 1 : 0;
        exp_err = (k == K_RO || k == K_NONE || (k == K_ONCE && once_flag));
        e_all = 2'b00; e_proc = 2'b00; e_one = 2'b00;
        if (k == K_IALL)  e_all  = 2'(1 << side);
        if (k == K_IPROC) e_proc = 2'(1 << side);
        if (k == K_IONE)  e_one  = 2'(1 << side);
        e_asn = side ? m[21][63:57] : m[20][10:4];
        do_op(1'b1, 1'b0, ix, p);
        chk(err_o == exp_err,
            (k == K_RO) ? "R8 write err" : (k == K_NONE) ? "R10 write err" :
            (k == K_ONCE) ? "R7 once err" : "R3 write no err", 64'(err_o), 64'(exp_err));
        chk(inv_all_o == e_all && inv_proc_o == e_proc, "R11 strobes",
            64'({inv_all_o, inv_proc_o}), 64'({e_all, e_proc}));
        chk(inv_one_o == e_one, "R12 single strobe", 64'(inv_one_o), 64'(e_one));
        if (k == K_IONE) begin
            chk(inv_addr_o == p, "R12 address", inv_addr_o, p);
            chk(inv_asn_o == e_asn, "R12 asn", 64'(inv_asn_o), 64'(e_asn));
        end
        case (k)
            K_PLAIN, K_CYC, K_WO: m[ix] = p & mask_of(ix);
            K_CLR, K_IALL, K_IPROC: m[ix] = 64'h0;
            K_IONE: m[ix] = p;
            K_ONCE: once_flag = 1'b1;
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [4];
        logic [63:0] a, b;
        pats[0] = '1;
        pats[1] = 64'h5555_5555_5555_5555;
        pats[2] = 64'hAAAA_AAAA_AAAA_AAAA;
        pats[3] = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 64; i++) m[i] = 64'h0;
        m[8] = HB;
        m[9] = 64'h6;
        m[ID_SLOT] = 64'(CPU);

        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(rd_valid_o == 1'b0 && err_o == 1'b0 && inv_all_o == 2'b00, "R1 idle after reset",
            64'({rd_valid_o, err_o, inv_all_o}), 64'h0);

        // R1: reset values over every index
        for (int ix = 0; ix < 64; ix++) check_read(ix, "R1 reset value");
        idle();
        chk(rd_valid_o == 1'b0 && rd_data_o == 64'h0, "R2 valid one cycle",
            64'(rd_valid_o), 64'h0);

        // R3 R4 R5 R7 R8 R9 R10 R11 R12: write then read sweep
        for (int ix = 0; ix < 64; ix++) begin
            for (int p = 0; p < 4; p++) begin
                check_write(ix, pats[p]);
                check_read(ix, (ix == 10) ? "R4 exc addr" :
                               (kind_of(ix) == K_CLR) ? "R5 clear" :
                               (kind_of(ix) == K_ONCE) ? "R7 once value" :
                               (kind_of(ix) == K_RO) ? "R8 read only" : "R3 masked value");
            end
        end
        idle();
        chk(err_o == 1'b0, "R10 err one cycle", 64'(err_o), 64'h0);

        // R6: live counter merge
        check_write(27, 64'hDEAD_BEEF_1234_5678);
        do_op(1'b0, 1'b0, 27, 64'h0);
        a = rd_data_o;
        repeat (5) idle();
        do_op(1'b0, 1'b0, 27, 64'h0);
        b = rd_data_o;
        chk(a[63:32] == 32'hDEAD_BEEF && b[63:32] == 32'hDEAD_BEEF, "R6 upper kept", b, 64'hDEAD_BEEF_0000_0000);
        chk(b[31:0] - a[31:0] == 32'd6, "R6 counter gap", 64'(b[31:0] - a[31:0]), 64'd6);

        // R13: speculative writes dropped
        do_op(1'b1, 1'b1, 0, 64'h7777);
        chk(err_o == 1'b0, "R13 no err", 64'(err_o), 64'h0);
        check_read(0, "R13 value kept");
        do_op(1'b1, 1'b1, 33, 64'h0);
        chk(inv_all_o == 2'b00, "R13 no strobe", 64'(inv_all_o), 64'h0);
        do_op(1'b1, 1'b1, 35, 64'h1000);
        chk(inv_one_o == 2'b00 && inv_addr_o == 64'h0, "R13 no single strobe", inv_addr_o, 64'h0);
        do_op(1'b1, 1'b1, 28, 64'h1);
        chk(err_o == 1'b0, "R13 once not hit", 64'(err_o), 64'h0);
        do_op(1'b1, 1'b1, 29, 64'h1);
        chk(err_o == 1'b0, "R13 read only not flagged", 64'(err_o), 64'h0);
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule